// File: doc/BRIEF.md
# Four-Coil Stepper Drive Sequencer

This block produces the four coil-driver levels for a stepper motor with four coil sets. It steps through a fixed full-step table in which two coils are energised at every step. The table can be walked forwards or backwards, and it wraps at either end, so the shaft keeps turning for as long as stepping is allowed.

The time between steps comes from two nested down-counters. An inner counter, reloaded from an 8-bit fine setting, expires every (fine+1) clocks. An outer counter, reloaded from an 8-bit coarse setting, counts those expiries and triggers a step after (coarse+1) of them. The fine setting therefore trims the speed in small increments, and the coarse setting scales it in large ones.

A run enable holds the motor in place, and an emergency stop overrides every other input. While either one is holding, the present coil pattern stays on the outputs, so the shaft is held in position. A one-cycle strobe marks each step.

Top module: `step_seq_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), the table index returns to entry 0, so `coil` reads 4'b1010 and `step_pulse` is 0. Both counters and the latched rates load from `fine_set` and `coarse_set`.
- R2: With `dir_rev` = 0, successive steps walk the table 4'b1010, 4'b1001, 4'b0101, 4'b0110 and then wrap to 4'b1010. `coil[3]` drives the first coil and `coil[0]` drives the last coil, and a 1 drives that coil high.
- R3: With `dir_rev` = 1, the table is walked in reverse: 4'b1010, 4'b0110, 4'b0101, 4'b1001, then 4'b1010 again. Direction is sampled only on the cycle a step is taken.
- R4: While stepping is allowed, a step is taken every (coarse+1)*(fine+1) clock cycles.
- R5: With both settings at 0, a step is taken on every clock cycle and `step_pulse` stays high.
- R6: `step_pulse` is high for one cycle per step. It rises in the same cycle that `coil` shows the new pattern.
- R7: While `run_en` is 0, `coil` keeps its value and `step_pulse` stays 0. Both counters reload from the latched rates, so partial progress is discarded and a full period follows re-enable.
- R8: A high `estop` holds stepping exactly as in R7 whatever `run_en` is. This includes the cycle on which a step would otherwise have been taken.
- R9: `fine_set` and `coarse_set` are sampled only when a step is taken. A change made during a period takes effect from the following period.
- R10: `coil` always has exactly two bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 lets the motor step, 0 holds it |
| dir_rev | input | 1 | 0 walks the table forwards, 1 walks it backwards |
| estop | input | 1 | Emergency stop, highest priority hold |
| fine_set | input | 8 | Inner count reload (fine speed) |
| coarse_set | input | 8 | Outer count reload (coarse speed) |
| coil | output | 4 | Coil drive levels, bit 3 is the first coil |
| step_pulse | output | 1 | One-cycle strobe per step |

## Verification
A step falling due and an emergency stop can land in the same cycle. The bench lets a period run to one cycle before its end and then raises `estop` on exactly the cycle on which the step would fire. It then expects the pattern to stay unchanged and the strobe to stay low, followed by a full fresh period after release. A second overlap, a rate change in mid-period, is judged by expecting the old period to complete before the new period length appears.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int IDX_W = 2;
  typedef logic [3:0] coil_t;

  // full-step drive table, two coils on per entry
  function automatic coil_t pattern_of(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 4'b1010;
      2'd1:    return 4'b1001;
      2'd2:    return 4'b0101;
      default: return 4'b0110;
    endcase
  endfunction

  // next table index; wraps naturally in IDX_W bits
  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] idx,
                                                input logic rev);
    return rev ? idx - 1'b1 : idx + 1'b1;
  endfunction
endpackage

// File: rtl/step_rate_timer.sv
module step_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [RATE_W-1:0] fine_set_i,
  input  logic [RATE_W-1:0] coarse_set_i,
  output logic              step_o
);
  logic [RATE_W-1:0] fine_cnt, coarse_cnt, fine_q, coarse_q;
  logic fine_done, coarse_done;

  assign fine_done   = (fine_cnt == '0);
  assign coarse_done = (coarse_cnt == '0);
  assign step_o      = run_i && fine_done && coarse_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_cnt   <= fine_set_i;
      coarse_cnt <= coarse_set_i;
      fine_q     <= fine_set_i;
      coarse_q   <= coarse_set_i;
    end else if (!run_i) begin
      fine_cnt   <= fine_q;
      coarse_cnt <= coarse_q;
    end else if (step_o) begin
      fine_cnt   <= fine_set_i;
      coarse_cnt <= coarse_set_i;
      fine_q     <= fine_set_i;
      coarse_q   <= coarse_set_i;
    end else if (fine_done) begin
      fine_cnt   <= fine_q;
      coarse_cnt <= coarse_cnt - 1'b1;
    end else begin
      fine_cnt   <= fine_cnt - 1'b1;
    end
  end

  // R4
  no_double_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o && (fine_set_i != '0 || coarse_set_i != '0)) |=> !step_o);
endmodule

// File: rtl/step_pattern_walker.sv
module step_pattern_walker
  import step_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_i,
  input  logic  rev_i,
  output coil_t coil_o,
  output logic  strobe_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= adv_i;
      if (adv_i) idx_q <= idx_next(idx_q, rev_i);
    end
  end

  assign coil_o = pattern_of(idx_q);

  // R6
  strobe_moves_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (strobe_o && coil_o != $past(coil_o)));
  // R10
  two_coils_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(coil_o) == 2);
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              dir_rev,
  input  logic              estop,
  input  logic [RATE_W-1:0] fine_set,
  input  logic [RATE_W-1:0] coarse_set,
  output logic [3:0]        coil,
  output logic              step_pulse
);
  logic run_ok;
  logic step_fire;

  assign run_ok = run_en && !estop;

  step_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run_ok),
    .fine_set_i   (fine_set),
    .coarse_set_i (coarse_set),
    .step_o       (step_fire)
  );

  step_pattern_walker u_walk (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (step_fire),
    .rev_i    (dir_rev),
    .coil_o   (coil),
    .strobe_o (step_pulse)
  );

  // R7
  hold_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!step_pulse && $stable(coil)));
  // R8
  estop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    estop |-> !step_fire);
endmodule

// File: tb/sim_step_seq_top.sv
module sim_step_seq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, dir_rev = 1'b0, estop = 1'b0;
  logic [7:0] fine_set = 8'd2, coarse_set = 8'd1;
  logic [3:0] coil;
  logic step_pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_seq_top u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .dir_rev(dir_rev), .estop(estop),
    .fine_set(fine_set), .coarse_set(coarse_set),
    .coil(coil), .step_pulse(step_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // counts falling edges until the strobe is seen
  task automatic wait_strobe(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (step_pulse || n > 5000) break;
    end
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    chk(coil == 4'b1010, "R1 coil", coil, 4'hA);
    chk(step_pulse == 1'b0, "R1 strobe", step_pulse, 0);
    rst = 1'b0; run_en = 1'b1;
    wait_strobe(n);
    chk(n == 6, "R1 first period", n, 6);
    chk(coil == 4'b1001, "R2 first step", coil, 4'h9);
  endtask

  task automatic t_forward();
    logic [3:0] exp_seq [3] = '{4'b0101, 4'b0110, 4'b1010};
    int n;
    for (int i = 0; i < 3; i++) begin
      wait_strobe(n);
      chk(n == 6, "R4 R6 period", n, 6);
      chk(coil == exp_seq[i], "R2 order", coil, exp_seq[i]);
    end
  endtask

  task automatic t_reverse();
    logic [3:0] exp_seq [4] = '{4'b0110, 4'b0101, 4'b1001, 4'b1010};
    int n;
    dir_rev = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_strobe(n);
      chk(n == 6, "R4 reverse period", n, 6);
      chk(coil == exp_seq[i], "R3 order", coil, exp_seq[i]);
    end
    dir_rev = 1'b0;
  endtask

  task automatic t_hold();
    int n;
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(coil == 4'b1010 && !step_pulse, "R7 hold", coil, 4'hA);
      chk($countones(coil) == 2, "R10 two coils", $countones(coil), 2);
    end
    run_en = 1'b1;
    wait_strobe(n);
    chk(n == 6, "R7 full period after enable", n, 6);
    chk(coil == 4'b1001, "R7 resume pattern", coil, 4'h9);
  endtask

  task automatic t_estop();
    int n;
    repeat (5) @(negedge clk);
    estop = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(coil == 4'b1001 && !step_pulse, "R8 estop on due step", coil, 4'h9);
    end
    estop = 1'b0;
    wait_strobe(n);
    chk(n == 6, "R8 full period after release", n, 6);
    chk(coil == 4'b0101, "R8 resume pattern", coil, 4'h5);
  endtask

  task automatic t_rate();
    int n;
    repeat (2) @(negedge clk);
    fine_set = 8'd0; coarse_set = 8'd3;
    wait_strobe(n);
    chk(n == 4, "R9 old period completes", n + 2, 6);
    chk(coil == 4'b0110, "R9 pattern", coil, 4'h6);
    wait_strobe(n);
    chk(n == 4, "R9 new period", n, 4);
    chk(coil == 4'b1010, "R9 wrap", coil, 4'hA);
  endtask

  task automatic t_min();
    logic [3:0] exp_seq [4] = '{4'b0101, 4'b0110, 4'b1010, 4'b1001};
    int n;
    fine_set = 8'd0; coarse_set = 8'd0;
    wait_strobe(n);
    chk(coil == 4'b1001, "R5 entry pattern", coil, 4'h9);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(step_pulse == 1'b1, "R5 strobe every cycle", step_pulse, 1);
      chk(coil == exp_seq[i], "R5 step every cycle", coil, exp_seq[i]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_estop();
    t_rate();
    t_min();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule